// File: doc/BRIEF.md
# Command Flit Serializer

This block turns one transaction-level command into a packet of 40-bit network flits. A command header (byte address, command kind, source identifier, two flag bits, length, thread and packet tags) is accepted on one valid/ready handshake. For a write-class command, the data words then follow on a second valid/ready handshake, one word per transfer, with a last-word marker. The flits leave on a third valid/ready stream.

Every packet starts with an address flit and a header flit. Read-class commands end on the header flit. Write-class commands add one flit per data word, and end-of-packet is carried by the flit built from the word marked last. Broadcast packets are never produced: the broadcast bit of the address flit is always zero.

Top module: `cmd_flit_serializer`

## Requirements
- R1: After reset, flit_valid and wd_ready are 0 and hdr_ready is 1.
- R2: The first flit of every packet is {1'b0, hdr_addr[39:2], 1'b0}. Bit 39 is the end flag and bit 0 is the broadcast flag.
- R3: The second flit is {eop, srcid[13:0], cmd[1:0], flags[1:0], plen[7:0], trdid[3:0], pktid[3:0], 5'b0}. The fields sit at bits 39, 38:25, 24:23, 22:21, 20:13, 12:9, 8:5 and 4:0.
- R4: Command code 2'b00 (read) and code 2'b10 (linked load) form the read class, with hdr_cmd[0]=0. A read-class packet is exactly two flits, and bit 39 is set in the second flit. After the second flit the block is idle again, with hdr_ready=1 and flit_valid=0.
- R5: Command code 2'b01 (write) and code 2'b11 (store conditional) form the write class, with hdr_cmd[0]=1. A write-class packet with N data words is N+2 flits. Bit 39 of the second flit is 0. Each data flit is {last, 3'b0, be[3:0], data[31:0]}.
- R6: Bit 39 of a data flit equals wd_last of its word, so end-of-packet is set on the last data flit only. After that flit the block is idle.
- R7: While flit_valid is 1 and flit_ready is 0, the flit is held unchanged. No flit is dropped or repeated.
- R8: hdr_ready is 0 from the cycle after a header is accepted until the last flit of its packet is taken. A header offered during that time is not taken.
- R9: wd_ready is 1 only in the data phase of a write-class packet, and there it equals flit_ready. Write data offered at any other time has no effect on the flits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Command header offered |
| hdr_ready | output | 1 | Header accepted this cycle when valid |
| hdr_addr | input | 40 | Byte address |
| hdr_cmd | input | 2 | Command code (bit 0 set = write class) |
| hdr_flags | input | 2 | Flag bits copied into the header flit |
| hdr_srcid | input | 14 | Source identifier |
| hdr_plen | input | 8 | Packet length in bytes |
| hdr_trdid | input | 4 | Thread tag |
| hdr_pktid | input | 4 | Packet tag |
| wd_valid | input | 1 | Write word offered |
| wd_ready | output | 1 | Write word taken this cycle when valid |
| wd_data | input | 32 | Write word |
| wd_be | input | 4 | Byte enables of the word |
| wd_last | input | 1 | Marks the final word of the command |
| flit_valid | output | 1 | Flit offered |
| flit_ready | input | 1 | Downstream takes the flit |
| flit_data | output | 40 | Flit contents |

## Verification
The in-RTL assertions check on every cycle that:
- a stalled flit is held stable;
- the header handshake is closed while flits are pending;
- the data handshake opens only together with a free output;
- an end-flagged flit returns the block to idle;
- the address flit matches the address captured a cycle earlier.

Only the bench scenarios can show that the whole packet is correct. This covers field positions in the header flit, the exact flit count for each command code, end-flag placement with one word and with many words, and the ignoring of stray write data and headers during a packet. They also cover stalls placed on the address, header and data flits.

// File: rtl/cmdser_pkg.sv
package cmdser_pkg;
   // Command code: bit 0 selects the write class.
   typedef enum logic [1:0] {
      CMD_READ  = 2'b00,
      CMD_WRITE = 2'b01,
      CMD_LLOAD = 2'b10,
      CMD_SCOND = 2'b11
   } cmd_code_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_HDR  = 2'd2,
      ST_DATA = 2'd3
   } ser_state_e;

   function automatic logic is_write_class(input logic [1:0] code);
      return code[0];
   endfunction
endpackage

// File: rtl/cmdser_hdr_stage.sv
module cmdser_hdr_stage #(
   parameter int FLIT_W  = 40,
   parameter int ADDR_W  = 40,
   parameter int SRCID_W = 14,
   parameter int PLEN_W  = 8,
   parameter int ID_W    = 4,
   parameter int FLAG_W  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [1:0]          cmd,
   input  logic [FLAG_W-1:0]   flags,
   input  logic [SRCID_W-1:0]  srcid,
   input  logic [PLEN_W-1:0]   plen,
   input  logic [ID_W-1:0]     trdid,
   input  logic [ID_W-1:0]     pktid,
   output logic                is_write,
   output logic [FLIT_W-1:0]   flit0,
   output logic [FLIT_W-2:0]   flit1_body
);
   import cmdser_pkg::*;

   localparam int WADDR_W = ADDR_W - 2;
   localparam int USED_W  = SRCID_W + 2 + FLAG_W + PLEN_W + 2 * ID_W;
   localparam int PAD_W   = FLIT_W - 1 - USED_W;

   generate
      if (WADDR_W + 2 != FLIT_W) begin : g_bad_addr
         $error("address flit width mismatch");
      end
      if (PAD_W < 0) begin : g_bad_hdr
         $error("header fields exceed flit width");
      end
   endgenerate

   logic [WADDR_W-1:0] waddr_q;
   logic [1:0]         cmd_q;
   logic [USED_W-1:0]  fields_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         waddr_q  <= '0;
         cmd_q    <= '0;
         fields_q <= '0;
      end else if (take) begin
         waddr_q  <= addr[ADDR_W-1:2];
         cmd_q    <= cmd;
         fields_q <= {srcid, cmd, flags, plen, trdid, pktid};
      end
   end

   assign is_write = is_write_class(cmd_q);
   assign flit0    = {1'b0, waddr_q, 1'b0};

   generate
      if (PAD_W > 0) begin : g_pad
         assign flit1_body = {fields_q, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign flit1_body = fields_q;
      end
   endgenerate

   // R2: the address flit reflects the address taken one cycle earlier
   p_addr_flit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (flit0[FLIT_W-1] == 1'b0) && (flit0[0] == 1'b0)
               && (flit0[FLIT_W-2:1] == $past(addr[ADDR_W-1:2])));
endmodule

// File: rtl/cmdser_data_fmt.sv
module cmdser_data_fmt #(
   parameter int FLIT_W = 40,
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]   data,
   input  logic [DATA_W/8-1:0] be,
   output logic [FLIT_W-2:0]   body
);
   localparam int BE_W  = DATA_W / 8;
   localparam int PAD_W = FLIT_W - 1 - BE_W - DATA_W;

   generate
      if (DATA_W % 8 != 0) begin : g_bad_data
         $error("data width must be a whole number of bytes");
      end
      if (PAD_W < 0) begin : g_bad_fit
         $error("data flit fields exceed flit width");
      end
      if (PAD_W > 0) begin : g_pad
         assign body = {{PAD_W{1'b0}}, be, data};
      end else begin : g_nopad
         assign body = {be, data};
      end
   endgenerate

   // R5: reserved bits of a data flit are zero whenever fields are defined
   always_comb begin
      if (PAD_W > 0 && !$isunknown(body))
         a_rsvd_zero_r5: assert (body[FLIT_W-2:FLIT_W-1-PAD_W] == '0);
   end
endmodule

// File: rtl/cmdser_ctrl.sv
module cmdser_ctrl #(
   parameter int FLIT_W = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_valid,
   output logic              hdr_ready,
   output logic              hdr_take,
   input  logic              is_write,
   input  logic [FLIT_W-1:0] flit0,
   input  logic [FLIT_W-2:0] flit1_body,
   input  logic [FLIT_W-2:0] dflit_body,
   input  logic              wd_valid,
   input  logic              wd_last,
   output logic              wd_ready,
   output logic              flit_valid,
   input  logic              flit_ready,
   output logic [FLIT_W-1:0] flit_data
);
   import cmdser_pkg::*;

   ser_state_e state_q, state_d;

   always_comb begin
      hdr_ready  = (state_q == ST_IDLE);
      hdr_take   = hdr_valid && hdr_ready;
      wd_ready   = 1'b0;
      flit_valid = 1'b0;
      flit_data  = '0;
      state_d    = state_q;
      unique case (state_q)
         ST_IDLE: if (hdr_valid) state_d = ST_ADDR;
         ST_ADDR: begin
            flit_valid = 1'b1;
            flit_data  = flit0;
            if (flit_ready) state_d = ST_HDR;
         end
         ST_HDR: begin
            flit_valid = 1'b1;
            flit_data  = {~is_write, flit1_body};
            if (flit_ready) state_d = is_write ? ST_DATA : ST_IDLE;
         end
         ST_DATA: begin
            flit_valid = wd_valid;
            wd_ready   = flit_ready;
            flit_data  = {wd_last, dflit_body};
            if (wd_valid && flit_ready && wd_last) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   // R7: a stalled flit stays put
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flit_valid && !flit_ready) |=> (flit_valid && $stable(flit_data)));
   // R8: no header is taken while flits are pending
   p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flit_valid |-> !hdr_ready);
   // R4 / R6: an end-flagged flit that is taken returns the block to idle
   p_eop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flit_valid && flit_ready && flit_data[FLIT_W-1]) |=> (hdr_ready && !flit_valid));
   // R9: data is taken only while the output is free and a packet is open
   p_wd_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wd_ready |-> (flit_ready && !hdr_ready));
endmodule

// File: rtl/cmd_flit_serializer.sv
module cmd_flit_serializer #(
   parameter int FLIT_W  = 40,
   parameter int ADDR_W  = 40,
   parameter int SRCID_W = 14,
   parameter int PLEN_W  = 8,
   parameter int ID_W    = 4,
   parameter int FLAG_W  = 2,
   parameter int DATA_W  = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hdr_valid,
   output logic                 hdr_ready,
   input  logic [ADDR_W-1:0]    hdr_addr,
   input  logic [1:0]           hdr_cmd,
   input  logic [FLAG_W-1:0]    hdr_flags,
   input  logic [SRCID_W-1:0]   hdr_srcid,
   input  logic [PLEN_W-1:0]    hdr_plen,
   input  logic [ID_W-1:0]      hdr_trdid,
   input  logic [ID_W-1:0]      hdr_pktid,
   input  logic                 wd_valid,
   output logic                 wd_ready,
   input  logic [DATA_W-1:0]    wd_data,
   input  logic [DATA_W/8-1:0]  wd_be,
   input  logic                 wd_last,
   output logic                 flit_valid,
   input  logic                 flit_ready,
   output logic [FLIT_W-1:0]    flit_data
);
   logic              take;
   logic              is_write;
   logic [FLIT_W-1:0] flit0;
   logic [FLIT_W-2:0] flit1_body;
   logic [FLIT_W-2:0] dflit_body;

   cmdser_hdr_stage #(
      .FLIT_W(FLIT_W), .ADDR_W(ADDR_W), .SRCID_W(SRCID_W),
      .PLEN_W(PLEN_W), .ID_W(ID_W), .FLAG_W(FLAG_W)
   ) u_hdr (
      .clk(clk), .rst_n(rst_n), .take(take),
      .addr(hdr_addr), .cmd(hdr_cmd), .flags(hdr_flags), .srcid(hdr_srcid),
      .plen(hdr_plen), .trdid(hdr_trdid), .pktid(hdr_pktid),
      .is_write(is_write), .flit0(flit0), .flit1_body(flit1_body)
   );

   cmdser_data_fmt #(.FLIT_W(FLIT_W), .DATA_W(DATA_W)) u_dfmt (
      .data(wd_data), .be(wd_be), .body(dflit_body)
   );

   cmdser_ctrl #(.FLIT_W(FLIT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_take(take),
      .is_write(is_write), .flit0(flit0), .flit1_body(flit1_body),
      .dflit_body(dflit_body),
      .wd_valid(wd_valid), .wd_last(wd_last), .wd_ready(wd_ready),
      .flit_valid(flit_valid), .flit_ready(flit_ready), .flit_data(flit_data)
   );
endmodule

// File: tb/cmd_flit_serializer_test.sv
module cmd_flit_serializer_test;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 7;

   typedef struct packed {
      logic [1:0]  cmd;
      logic [39:0] addr;
      logic [13:0] src;
      logic [1:0]  flg;
      logic [7:0]  plen;
      logic [3:0]  trd;
      logic [3:0]  pkt;
      logic [3:0]  nw;
      logic [15:0] stall;
      logic        noise;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{2'b00, 40'h12_3456_789C, 14'h2A5B, 2'b01, 8'd4,  4'h3, 4'hC, 4'd0, 16'h0000, 1'b0},
      '{2'b10, 40'hFF_FFFF_FFFC, 14'h3FFF, 2'b11, 8'd4,  4'hF, 4'hF, 4'd0, 16'h0003, 1'b1},
      '{2'b01, 40'h00_0000_0003, 14'h0001, 2'b00, 8'd4,  4'h0, 4'h1, 4'd1, 16'h0000, 1'b0},
      '{2'b01, 40'hA5_5A00_1234, 14'h1555, 2'b10, 8'd16, 4'h7, 4'h8, 4'd4, 16'h002A, 1'b0},
      '{2'b11, 40'h80_0000_0010, 14'h0800, 2'b01, 8'd4,  4'h9, 4'h6, 4'd1, 16'h0007, 1'b1},
      '{2'b01, 40'h7F_FFFF_FFF0, 14'h2AAA, 2'b11, 8'd32, 4'h5, 4'hA, 4'd8, 16'h0201, 1'b1},
      '{2'b00, 40'h00_0000_0000, 14'h0000, 2'b00, 8'd0,  4'h0, 4'h0, 4'd0, 16'h0002, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hdr_valid = 1'b0;
   logic        hdr_ready;
   logic [39:0] hdr_addr = '0;
   logic [1:0]  hdr_cmd = '0;
   logic [1:0]  hdr_flags = '0;
   logic [13:0] hdr_srcid = '0;
   logic [7:0]  hdr_plen = '0;
   logic [3:0]  hdr_trdid = '0;
   logic [3:0]  hdr_pktid = '0;
   logic        wd_valid = 1'b0;
   logic        wd_ready;
   logic [31:0] wd_data = '0;
   logic [3:0]  wd_be = '0;
   logic        wd_last = 1'b0;
   logic        flit_valid;
   logic        flit_ready = 1'b0;
   logic [39:0] flit_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmd_flit_serializer uut (
      .clk(clk), .rst_n(rst_n),
      .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_addr(hdr_addr),
      .hdr_cmd(hdr_cmd), .hdr_flags(hdr_flags), .hdr_srcid(hdr_srcid),
      .hdr_plen(hdr_plen), .hdr_trdid(hdr_trdid), .hdr_pktid(hdr_pktid),
      .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
      .wd_be(wd_be), .wd_last(wd_last),
      .flit_valid(flit_valid), .flit_ready(flit_ready), .flit_data(flit_data)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] wdat(input int i, input int k);
      return 32'hC0DE_0000 ^ (32'(i) << 20) ^ 32'(k * 17);
   endfunction

   function automatic logic [3:0] wbe(input int i, input int k);
      return 4'(k + i + 1);
   endfunction

   task automatic run_vec(input int i);
      vec_t v = VECS[i];
      bit wr = v.cmd[0];
      int total = wr ? int'(v.nw) + 2 : 2;
      int idx = 0;
      bit stalled_here = 1'b0;
      logic [39:0] exp;
      @(negedge clk);
      hdr_valid = 1'b1; hdr_addr = v.addr; hdr_cmd = v.cmd; hdr_flags = v.flg;
      hdr_srcid = v.src; hdr_plen = v.plen; hdr_trdid = v.trd; hdr_pktid = v.pkt;
      #1 chk("R8 idle hdr_ready", 64'(hdr_ready), 64'd1);
      @(posedge clk);
      while (idx < total) begin
         @(negedge clk);
         if (v.noise) begin
            hdr_valid = 1'b1; hdr_addr = ~v.addr; hdr_cmd = ~v.cmd; hdr_srcid = ~v.src;
         end else begin
            hdr_valid = 1'b0;
         end
         if (idx >= 2) begin
            wd_valid = 1'b1; wd_data = wdat(i, idx - 2); wd_be = wbe(i, idx - 2);
            wd_last = (idx == total - 1);
         end else begin
            wd_valid = v.noise; wd_data = 32'hDEAD_BEEF; wd_be = 4'hF; wd_last = 1'b1;
         end
         flit_ready = !(v.stall[idx] && !stalled_here);
         #1;
         if (idx == 0)      exp = {1'b0, v.addr[39:2], 1'b0};
         else if (idx == 1) exp = {!wr, v.src, v.cmd, v.flg, v.plen, v.trd, v.pkt, 5'b0};
         else exp = {(idx == total - 1), 3'b000, wbe(i, idx - 2), wdat(i, idx - 2)};
         if (stalled_here)
            chk("R7 flit held through stall", {23'd0, flit_valid, flit_data}, {23'd0, 1'b1, exp});
         else if (idx == 0)
            chk("R2 address flit", {23'd0, flit_valid, flit_data}, {23'd0, 1'b1, exp});
         else if (idx == 1)
            chk(wr ? "R3 R5 header flit" : "R3 R4 header flit",
                {23'd0, flit_valid, flit_data}, {23'd0, 1'b1, exp});
         else if (idx == total - 1)
            chk("R6 last data flit", {23'd0, flit_valid, flit_data}, {23'd0, 1'b1, exp});
         else
            chk("R5 data flit", {23'd0, flit_valid, flit_data}, {23'd0, 1'b1, exp});
         chk("R8 hdr_ready during packet", 64'(hdr_ready), 64'd0);
         chk("R9 wd_ready", 64'(wd_ready), 64'((idx >= 2) && flit_ready));
         @(posedge clk);
         if (flit_ready) begin
            idx++;
            stalled_here = 1'b0;
         end else begin
            stalled_here = 1'b1;
         end
      end
      @(negedge clk);
      hdr_valid = 1'b0; wd_valid = 1'b0; wd_last = 1'b0; flit_ready = 1'b1;
      #1;
      chk(wr ? "R5 packet ends idle" : "R4 packet ends idle",
          {62'd0, flit_valid, hdr_ready}, {62'd0, 1'b0, 1'b1});
      chk("R9 wd_ready idle", 64'(wd_ready), 64'd0);
   endtask

   initial begin
      fork
         begin
            repeat (20000) @(posedge clk);
            if (!done) begin
               errors++;
               $display("FAIL R7 watchdog expired actual=hung expected=finish");
               $display("Result: errors=%0d of %0d checks", errors, checks + 1);
               $finish;
            end
         end
      join_none

      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      chk("R1 reset state", {61'd0, flit_valid, wd_ready, hdr_ready}, {61'd0, 3'b001});
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) run_vec(i);

      // R9: stray write data while idle produces no flit
      @(negedge clk);
      wd_valid = 1'b1; wd_last = 1'b1; wd_data = 32'h1234_5678; flit_ready = 1'b1;
      #1 chk("R9 idle stray data", {62'd0, flit_valid, wd_ready}, 64'd0);
      @(negedge clk);
      #1 chk("R9 idle stray data later", {62'd0, flit_valid, wd_ready}, 64'd0);
      wd_valid = 1'b0;

      // R4: flits continue back to back after a stray-data idle
      run_vec(0);

      // R1: reset in mid-packet clears the packet
      @(negedge clk);
      hdr_valid = 1'b1; hdr_cmd = 2'b01; flit_ready = 1'b0;
      @(negedge clk);
      hdr_valid = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      #1 chk("R1 reset mid-packet", {61'd0, flit_valid, wd_ready, hdr_ready}, {61'd0, 3'b001});
      rst_n = 1'b1;
      run_vec(3);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule